// File: doc/BRIEF.md
# Sync Frequency Measurement Engine

This block times a display's incoming sync with one shared up counter. It takes turns between two measurements. In vertical mode it counts timebase ticks across one frame, giving the frame period. In horizontal mode it counts line-sync rising edges inside a fixed window of timebase ticks. When a result is ready, the count and a ready flag are presented. Software reads the count, and that read moves the engine on to the other measurement.

The counter uses two overflow flags. After the first wrap, counting continues. A second wrap ends the measurement and reports it as ready. This lets software tell a very slow frame rate, or no sync at all, apart from a valid reading.

A composite select makes the vertical measurement take its frame marker from the line-sync input. In that case a frame marker is a high level lasting at least a fixed number of ticks. Both sync inputs pass through a two-flop synchronizer and are detected on their rising edge.

Top module: `sync_freq_meter`

## Requirements
- R1: After reset, count_o, ready_o, ovf1_o, ovf2_o and irq_o are 0, and mode_o is 0 (vertical).
- R2: In vertical mode with comp_sel 0, the first rising edge of vsync_in after the mode is entered zeroes the counter. Each later tick adds 1, and the next rising edge makes the result ready. A tick in the same cycle as an edge is not counted. Line-sync activity has no effect.
- R3: In horizontal mode (mode_o 1), count_o is the number of hsync_in rising edges seen in the window. The window starts when the mode is entered and ends on its HWIN_TICKS-th tick, which makes the result ready.
- R4: While ready_o is 1, further sync pulses and ticks leave count_o and the flags unchanged.
- R5: A cnt_rd pulse while ready_o is 1 in vertical mode clears ready_o, count_o, both overflow flags and irq_o, and sets mode_o to 1.
- R6: A cnt_rd pulse while ready_o is 1 in horizontal mode clears ready_o, count_o, both overflow flags and irq_o, and sets mode_o to 0.
- R7: A cnt_rd pulse while ready_o is 0 has no effect on mode_o, count_o or ready_o.
- R8: The counter wraps from its maximum value to 0. The first wrap sets ovf1_o and counting continues. The second wrap sets ovf2_o and ready_o. The counter runs from mode entry, so a vertical measurement with no sync still ends.
- R9: irq_o is set together with ready_o only when irq_en is 1. It stays set until the clearing read.
- R10: With comp_sel 1, the vertical marker fires once per pulse, on the VSEP_TICKS-th tick during which hsync_in is high. Shorter high pulses and vsync_in are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Line or composite sync, active high, asynchronous |
| vsync_in | input | 1 | Frame sync, active high, asynchronous |
| tick_en | input | 1 | One-cycle timebase strobe (31.25 kHz nominal) |
| comp_sel | input | 1 | 1: take the frame marker from hsync_in |
| irq_en | input | 1 | Enables the interrupt when a result becomes ready |
| cnt_rd | input | 1 | One-cycle strobe: the count register is being read |
| count_o | output | CNT_W | Measurement count |
| ready_o | output | 1 | Result ready |
| mode_o | output | 1 | 0 vertical, 1 horizontal |
| ovf1_o | output | 1 | Counter has wrapped once |
| ovf2_o | output | 1 | Counter has wrapped twice |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench uses a 4-bit counter, an 8-tick window and a 3-tick frame-marker width. It sweeps every count value in both modes and alternates the interrupt enable between rounds.

It aims at the following faults:
- **Tick on an edge cycle.** If a tick coinciding with the closing edge were counted, every vertical result would be off by one.
- **Reads.** A read that is not gated by ready would flip the mode during a measurement. Missing freeze logic would let extra ticks change a ready count.
- **Overflow.** A single-stage overflow would end a sync-less vertical measurement after one wrap instead of two, or never end it.
- **Composite markers.** A marker that fired on short pulses, or more than once per wide pulse, would close the frame early. That gives a count other than 7 on the composite pattern.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
  typedef enum logic {
    MODE_VERT = 1'b0,
    MODE_HORZ = 1'b1
  } meas_mode_e;
endpackage

// File: rtl/sfm_sync.sv
module sfm_sync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= din[g];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign lvl[g]  = s2_q;
    assign rise[g] = s2_q & ~s3_q;
  end
endmodule

// File: rtl/sfm_vsep.sv
module sfm_vsep #(
  parameter int TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic lvl,
  output logic vpulse
);
  localparam int WW = (TICKS < 2) ? 1 : $clog2(TICKS);
  localparam logic [WW-1:0] LAST = WW'(TICKS - 1);

  logic [WW-1:0] w_q, w_d;
  logic          f_q, f_d;

  always_comb begin
    w_d    = w_q;
    f_d    = f_q;
    vpulse = tick & lvl & ~f_q & (w_q == LAST);
    if (!lvl) begin
      w_d = '0;
      f_d = 1'b0;
    end else if (tick && !f_q) begin
      if (w_q == LAST) begin
        f_d = 1'b1;
        w_d = '0;
      end else begin
        w_d = w_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q <= '0;
      f_q <= 1'b0;
    end else begin
      w_q <= w_d;
      f_q <= f_d;
    end
  end

  // R10: a marker needs the line sync high
  p_marker_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
    vpulse |-> lvl);
  // R10: at most one marker per wide pulse
  p_marker_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    vpulse |=> !vpulse);
endmodule

// File: rtl/sfm_seq.sv
module sfm_seq
  import sfm_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int HWIN  = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             vedge,
  input  logic             hedge,
  input  logic             rd,
  input  logic             irq_en,
  output logic [CNT_W-1:0] count,
  output logic             ready,
  output meas_mode_e       mode,
  output logic             ovf1,
  output logic             ovf2,
  output logic             irq
);
  localparam int WIN_W = (HWIN < 2) ? 1 : $clog2(HWIN);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(HWIN - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [WIN_W-1:0] win_q, win_d;
  meas_mode_e       mode_q, mode_d;
  logic             armed_q, armed_d;
  logic             ready_q, ready_d;
  logic             ovf1_q, ovf1_d;
  logic             ovf2_q, ovf2_d;
  logic             irq_q, irq_d;
  logic             inc, done;

  always_comb begin
    cnt_d   = cnt_q;
    win_d   = win_q;
    mode_d  = mode_q;
    armed_d = armed_q;
    ready_d = ready_q;
    ovf1_d  = ovf1_q;
    ovf2_d  = ovf2_q;
    irq_d   = irq_q;
    inc     = 1'b0;
    done    = 1'b0;
    if (ready_q) begin
      if (rd) begin
        ready_d = 1'b0;
        irq_d   = 1'b0;
        cnt_d   = '0;
        win_d   = '0;
        ovf1_d  = 1'b0;
        ovf2_d  = 1'b0;
        armed_d = 1'b0;
        mode_d  = (mode_q == MODE_VERT) ? MODE_HORZ : MODE_VERT;
      end
    end else begin
      if (mode_q == MODE_VERT) begin
        if (vedge) begin
          if (armed_q) begin
            done = 1'b1;
          end else begin
            armed_d = 1'b1;
            cnt_d   = '0;
            ovf1_d  = 1'b0;
          end
        end else if (tick) begin
          inc = 1'b1;
        end
      end else begin
        inc = hedge;
        if (tick) begin
          if (win_q == WIN_LAST) done = 1'b1;
          else                   win_d = win_q + 1'b1;
        end
      end
      if (inc) begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CNT_MAX) begin
          if (ovf1_q) begin
            ovf2_d = 1'b1;
            done   = 1'b1;
          end else begin
            ovf1_d = 1'b1;
          end
        end
      end
      if (done) begin
        ready_d = 1'b1;
        irq_d   = irq_en;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      win_q   <= '0;
      mode_q  <= MODE_VERT;
      armed_q <= 1'b0;
      ready_q <= 1'b0;
      ovf1_q  <= 1'b0;
      ovf2_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      win_q   <= win_d;
      mode_q  <= mode_d;
      armed_q <= armed_d;
      ready_q <= ready_d;
      ovf1_q  <= ovf1_d;
      ovf2_q  <= ovf2_d;
      irq_q   <= irq_d;
    end
  end

  assign count = cnt_q;
  assign ready = ready_q;
  assign mode  = mode_q;
  assign ovf1  = ovf1_q;
  assign ovf2  = ovf2_q;
  assign irq   = irq_q;

  // R5/R6: the mode only steps on a read of a ready result
  p_mode_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> $past(rd && ready_q));
  // R4: a ready result is frozen until read
  p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_q && !rd) |=> ($stable(cnt_q) && ready_q));
  // R6: a read of a ready result clears it
  p_rd_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && ready_q) |=> (!ready_q && !irq_q && cnt_q == '0));
  // R7: a read with nothing ready leaves the mode
  p_idle_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !ready_q) |=> $stable(mode_q));
  // R8: second wrap implies first wrap and a ready result
  p_ovf_stage_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf2_q |-> (ovf1_q && ready_q));
  // R9: no interrupt without a ready result
  p_irq_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> ready_q);
endmodule

// File: rtl/sync_freq_meter.sv
module sync_freq_meter #(
  parameter int CNT_W      = 10,
  parameter int HWIN_TICKS = 256,
  parameter int VSEP_TICKS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync_in,
  input  logic             vsync_in,
  input  logic             tick_en,
  input  logic             comp_sel,
  input  logic             irq_en,
  input  logic             cnt_rd,
  output logic [CNT_W-1:0] count_o,
  output logic             ready_o,
  output logic             mode_o,
  output logic             ovf1_o,
  output logic             ovf2_o,
  output logic             irq_o
);
  import sfm_pkg::*;

  localparam int HS = 0;
  localparam int VS = 1;

  logic [1:0]  s_lvl, s_rise;
  logic        comp_mark, vedge;
  meas_mode_e  mode_e;

  sfm_sync #(.N(2)) i_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({vsync_in, hsync_in}),
    .lvl  (s_lvl),
    .rise (s_rise)
  );

  sfm_vsep #(.TICKS(VSEP_TICKS)) i_vsep (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_en),
    .lvl   (s_lvl[HS]),
    .vpulse(comp_mark)
  );

  assign vedge = comp_sel ? comp_mark : s_rise[VS];

  sfm_seq #(.CNT_W(CNT_W), .HWIN(HWIN_TICKS)) i_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_en),
    .vedge (vedge),
    .hedge (s_rise[HS]),
    .rd    (cnt_rd),
    .irq_en(irq_en),
    .count (count_o),
    .ready (ready_o),
    .mode  (mode_e),
    .ovf1  (ovf1_o),
    .ovf2  (ovf2_o),
    .irq   (irq_o)
  );

  assign mode_o = mode_e;
endmodule

// File: tb/test_sync_freq_meter.sv
module test_sync_freq_meter;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 4;
  localparam int HW = 8;
  localparam int VT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync_in = 1'b0, vsync_in = 1'b0, tick_en = 1'b0;
  logic comp_sel = 1'b0, irq_en = 1'b0, cnt_rd = 1'b0;
  logic [CW-1:0] count_o;
  logic ready_o, mode_o, ovf1_o, ovf2_o, irq_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_freq_meter #(.CNT_W(CW), .HWIN_TICKS(HW), .VSEP_TICKS(VT)) i_sync_freq_meter (
    .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .tick_en(tick_en), .comp_sel(comp_sel), .irq_en(irq_en), .cnt_rd(cnt_rd),
    .count_o(count_o), .ready_o(ready_o), .mode_o(mode_o),
    .ovf1_o(ovf1_o), .ovf2_o(ovf2_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      tick_en = 1'b1; step(1);
      tick_en = 1'b0; step(1);
    end
  endtask

  task automatic vpulse();
    vsync_in = 1'b1; step(4);
    vsync_in = 1'b0; step(4);
  endtask

  task automatic hpulse(input int nt);
    hsync_in = 1'b1; step(4);
    ticks(nt);
    hsync_in = 1'b0; step(4);
  endtask

  task automatic rd();
    cnt_rd = 1'b1; step(1);
    cnt_rd = 1'b0; step(2);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    step(1000000 / CLK_PERIOD / 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    step(3);
    // R1 reset state
    check("R1 count", int'(count_o), 0);
    check("R1 ready", int'(ready_o), 0);
    check("R1 mode", int'(mode_o), 0);
    check("R1 ovf", int'({ovf1_o, ovf2_o}), 0);
    check("R1 irq", int'(irq_o), 0);
    rst_n = 1'b1; step(2);

    for (int i = 0; i < 16; i++) begin
      irq_en = i[0];
      // R2 vertical period
      vpulse(); ticks(i); vpulse();
      check("R2 vcount", int'(count_o), i);
      check("R2 vready", int'(ready_o), 1);
      check("R9 irq", int'(irq_o), int'(irq_en));
      if (i == 5) begin
        ticks(3); vpulse(); hpulse(0);
        check("R4 frozen count", int'(count_o), 5);
        check("R4 frozen ready", int'(ready_o), 1);
      end
      rd();
      check("R5 mode", int'(mode_o), 1);
      check("R5 ready", int'(ready_o), 0);
      check("R5 count", int'(count_o), 0);
      // R3 horizontal pulse count
      for (int k = 0; k < 15 - i; k++) hpulse(0);
      check("R3 not ready before window", int'(ready_o), 0);
      ticks(HW);
      check("R3 hcount", int'(count_o), 15 - i);
      check("R3 hready", int'(ready_o), 1);
      rd();
      check("R6 mode", int'(mode_o), 0);
      check("R6 irq", int'(irq_o), 0);
    end

    irq_en = 1'b0;
    // R8 vertical single wrap
    vpulse(); ticks(17); vpulse();
    check("R8 vcount wrap", int'(count_o), 1);
    check("R8 ovf1", int'(ovf1_o), 1);
    check("R8 ovf2", int'(ovf2_o), 0);
    check("R9 irq masked", int'(irq_o), 0);
    rd();
    check("R8 ovf1 cleared", int'(ovf1_o), 0);
    // R8 horizontal single wrap
    for (int k = 0; k < 16; k++) hpulse(0);
    check("R8 hwrap ovf1", int'(ovf1_o), 1);
    check("R8 hwrap ready", int'(ready_o), 0);
    ticks(HW);
    check("R8 hwrap count", int'(count_o), 0);
    check("R8 hwrap ready end", int'(ready_o), 1);
    rd();
    // R8 no sync in vertical
    ticks(16);
    check("R8 nosync ovf1", int'(ovf1_o), 1);
    check("R8 nosync not ready", int'(ready_o), 0);
    ticks(16);
    check("R8 nosync ovf2", int'(ovf2_o), 1);
    check("R8 nosync ready", int'(ready_o), 1);
    check("R8 nosync count", int'(count_o), 0);
    rd();
    // R7 idle read ignored
    hpulse(0);
    rd();
    check("R7 mode", int'(mode_o), 1);
    check("R7 ready", int'(ready_o), 0);
    check("R7 count", int'(count_o), 1);
    hpulse(0); hpulse(0); ticks(HW);
    check("R7 count kept", int'(count_o), 3);
    rd();

    // R10 composite marker
    comp_sel = 1'b1;
    hpulse(4);
    hpulse(2); hpulse(2); vpulse();
    check("R10 short ignored", int'(ready_o), 0);
    hpulse(4);
    check("R10 ccount", int'(count_o), 7);
    check("R10 cready", int'(ready_o), 1);
    rd();
    hpulse(0); hpulse(0); ticks(HW);
    check("R3 hcount comp", int'(count_o), 2);
    rd();
    // R2 hsync ignored when not composite
    comp_sel = 1'b0;
    vpulse(); ticks(5); hpulse(4); vpulse();
    check("R2 hsync ignored", int'(count_o), 9);
    check("R2 ready", int'(ready_o), 1);
    summary();
  end
endmodule